// File: doc/BRIEF.md
# Bus Slave Address Router

This block sits between one 32-bit bus master and a small, fixed set of slaves. Each slave owns an address region that is set at elaboration time: a base address and the number of upper address bits that identify it. On every master cycle the router finds the slave whose region contains the address. It raises that slave's strobe and write enable and returns that slave's read data and acknowledge to the master. Every other slave sees an idle bus.

The router also converts the master byte address into the local address that each slave expects. A slave in byte mode receives the byte address. A slave in word mode receives a word index, scaled to its own data width. The result is cut to the slave's own address width. An access that matches no region receives an error acknowledge, so the master is never left waiting. Interrupt lines that no slave claims are combined into one spare interrupt output.

The decode can cover a full 32-bit memory space or a 24-bit peripheral space. In the 24-bit case address bits 31..24 take no part in the decode.

Top module: `sar_router`

## Requirements
- R1: A slave is hit when the top DEC_W bits of the address space equal the same bits of its base address. These are bits [31:32-DEC_W] in a 32-bit space and bits [23:24-DEC_W] in a 24-bit space, where bits 31..24 are ignored.
- R2: At most one slave strobe is high at a time. Only the hit slave gets the strobe, and its write enable is the strobe ANDed with the master write enable. The master write data goes unchanged to every slave.
- R3: A byte-mode slave receives the master address unchanged, so master bit 0 becomes local bit 0.
- R4: A word-mode slave with a 32-bit data width receives the master address shifted right by 2, so master bit 2 becomes local bit 0.
- R5: A word-mode slave with a 16-bit data width receives the master address shifted right by 1. A word-mode slave with an 8-bit data width receives the same address as in byte mode.
- R6: Local address bits at and above the slave's own address width are zero.
- R7: The master read data and acknowledge come from the selected slave only. An acknowledge from any other slave has no effect.
- R8: A strobe that hits no slave raises the error output for exactly one cycle after the clock edge that sees it, and the acknowledge stays low.
- R9: The spare interrupt output is the OR of the interrupt inputs that are not marked as used. Used inputs have no effect on it.
- R10: While reset is low, the error output goes low at the next clock edge.
- R11: No two slave regions overlap under the chosen parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_adr | input | 32 | Master byte address |
| m_dat_w | input | 32 | Master write data |
| m_we | input | 1 | Master write enable |
| m_stb | input | 1 | Master strobe (cycle valid) |
| m_dat_r | output | 32 | Read data of the selected slave |
| m_ack | output | 1 | Acknowledge of the selected slave |
| m_err | output | 1 | Error acknowledge for an unmapped access |
| s_adr | output | NS*32 | Local address per slave, slave 0 in the low bits |
| s_dat_w | output | 32 | Write data to all slaves |
| s_we | output | NS | Per-slave write enable |
| s_stb | output | NS | Per-slave strobe |
| s_dat_r | input | NS*32 | Read data per slave |
| s_ack | input | NS | Acknowledge per slave |
| irq_in | input | IRQ_W | Interrupt inputs |
| irq_spare | output | 1 | OR of the interrupt inputs no slave claims |

## Verification
The bench drives addresses at the bottom, middle and top of each region, and also just past the end of a slave's address width. These addresses catch a wrong shift for a given data width: it would give a local address off by a factor of two or four. They also catch a missing truncation, which would leak high bits into the local address. Acknowledges are driven from slaves that were not selected, to catch a read multiplexer that ORs all slaves together. An unmapped access is held in order to catch an error output that stays high or never rises. A second instance with a 24-bit space drives garbage into bits 31..24 to catch a decode that looks at the wrong bit field. The interrupt test raises only used lines, to catch a merge that ignores the used mask.

// File: rtl/sar_pkg.sv
// Package: shared constants and elaboration-time helpers for the router.
// Assumes a 32-bit master address bus.
package sar_pkg;

    localparam int unsigned ADDR_W = 32;

    // Build the mask of the decoded bit field: the top dec_w bits of a space_w-bit space.
    function automatic logic [ADDR_W-1:0] region_mask(int unsigned space_w, int unsigned dec_w);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            if ((k < space_w) && (k + dec_w >= space_w)) m[k] = 1'b1;
        end
        return m;
    endfunction

    // Right shift that turns a byte address into a word index for one slave.
    function automatic int unsigned lane_shift(logic word_mode, int unsigned data_w);
        if (!word_mode) return 0;
        case (data_w)
            16:      return 1;
            32:      return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sar_match.sv
// Module: region comparator for one slave.
// Raises hit when the address bits selected by MASK equal the same bits of BASE.
// Assumes MASK is non-zero.
module sar_match
    import sar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '1
) (
    input  logic [ADDR_W-1:0] adr,
    output logic              hit
);

    // Compare only the decoded field.
    always_comb begin
        hit = (((adr ^ BASE) & MASK) == '0);
    end

endmodule

// File: rtl/sar_xlate.sv
// Module: master-to-local address translation for one slave.
// Shifts the byte address by SHIFT (0 in byte mode) and keeps AW bits.
// Assumes 1 <= AW <= 32 and SHIFT + AW <= 32. Clock and reset feed the assertions only.
module sar_xlate
    import sar_pkg::*;
#(
    parameter int unsigned SHIFT = 0,
    parameter int unsigned AW    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] adr,
    output logic [ADDR_W-1:0] loc
);

    localparam logic [ADDR_W-1:0] LMASK =
        (AW >= ADDR_W) ? {ADDR_W{1'b1}} : ((ADDR_W'(1) << AW) - ADDR_W'(1));

    // Scale to the word index and cut to the slave's address width.
    always_comb begin
        loc = (adr >> SHIFT) & LMASK;
    end

    // R3 R4 R5: local bit 0 follows the master bit picked by the mode.
    a_r4_lsb_map: assert property (@(posedge clk) disable iff (!rst_n)
        loc[0] == adr[SHIFT]);

    // R6: nothing leaks above the slave's address width.
    a_r6_width_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (AW >= ADDR_W) || ((loc >> AW) == '0));

endmodule

// File: rtl/sar_irq_merge.sv
// Module: folds every interrupt line that no slave claims into one spare output.
// USED marks the claimed lines with ones.
module sar_irq_merge #(
    parameter int unsigned        IRQ_W = 8,
    parameter logic [IRQ_W-1:0]   USED  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] irq_in,
    output logic             irq_spare
);

    // OR of the unclaimed lines.
    always_comb begin
        irq_spare = |(irq_in & ~USED);
    end

    // R9: when the unclaimed lines are steady, the spare output is steady too.
    a_r9_used_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(irq_in & ~USED) |-> $stable(irq_spare));

endmodule

// File: rtl/sar_router.sv
// Module: single-master address router for NS slaves.
// Decodes each slave region and routes the strobe, write enable and data to the
// hit slave. Returns that slave's read data and acknowledge, and answers unmapped
// strobes with a one-cycle error. Assumes non-overlapping regions; if regions
// overlap, the lowest index wins. Slave k parameters sit in field k of each packed vector.
module sar_router
    import sar_pkg::*;
#(
    parameter int unsigned            NS       = 4,
    parameter int unsigned            IRQ_W    = 8,
    parameter int unsigned            SPACE_W  = 32,
    parameter logic [NS*ADDR_W-1:0]   SLV_BASE = {32'h0300_0000, 32'h0200_0000,
                                                  32'h0400_0000, 32'h0100_0000},
    parameter logic [NS*8-1:0]        SLV_DECW = {8'd8, 8'd8, 8'd8, 8'd8},
    parameter logic [NS-1:0]          SLV_WORD = 4'b1110,
    parameter logic [NS*8-1:0]        SLV_DW   = {8'd8, 8'd16, 8'd32, 8'd32},
    parameter logic [NS*8-1:0]        SLV_AW   = {8'd8, 8'd12, 8'd4, 8'd20},
    parameter logic [IRQ_W-1:0]       IRQ_USED = 8'b0000_1111
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     m_adr,
    input  logic [31:0]           m_dat_w,
    input  logic                  m_we,
    input  logic                  m_stb,
    output logic [31:0]           m_dat_r,
    output logic                  m_ack,
    output logic                  m_err,
    output logic [NS*ADDR_W-1:0]  s_adr,
    output logic [31:0]           s_dat_w,
    output logic [NS-1:0]         s_we,
    output logic [NS-1:0]         s_stb,
    input  logic [NS*32-1:0]      s_dat_r,
    input  logic [NS-1:0]         s_ack,
    input  logic [IRQ_W-1:0]      irq_in,
    output logic                  irq_spare
);

    logic [NS-1:0] hit;
    logic [NS-1:0] sel;
    logic          miss;
    logic          err_q;

    // One comparator and one translator per slave.
    for (genvar i = 0; i < NS; i++) begin : g_slv
        localparam logic [ADDR_W-1:0] BASE_I  = SLV_BASE[i*ADDR_W +: ADDR_W];
        localparam int unsigned       DECW_I  = int'(SLV_DECW[i*8 +: 8]);
        localparam int unsigned       DW_I    = int'(SLV_DW[i*8 +: 8]);
        localparam int unsigned       AW_I    = int'(SLV_AW[i*8 +: 8]);
        localparam logic [ADDR_W-1:0] MASK_I  = region_mask(SPACE_W, DECW_I);
        localparam int unsigned       SHIFT_I = lane_shift(SLV_WORD[i], DW_I);

        sar_match #(.BASE(BASE_I), .MASK(MASK_I)) i_match (
            .adr (m_adr),
            .hit (hit[i])
        );

        sar_xlate #(.SHIFT(SHIFT_I), .AW(AW_I)) i_xlate (
            .clk   (clk),
            .rst_n (rst_n),
            .adr   (m_adr),
            .loc   (s_adr[i*ADDR_W +: ADDR_W])
        );
    end

    // Keep the select one-hot: the lowest hit index wins.
    always_comb begin
        logic taken;
        sel   = '0;
        taken = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (hit[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    // Forward the strobe, write enable and data to the selected slave.
    always_comb begin
        s_stb   = sel & {NS{m_stb}};
        s_we    = sel & {NS{m_stb & m_we}};
        s_dat_w = m_dat_w;
        miss    = m_stb & ~(|sel);
    end

    // Return the read data and acknowledge of the selected slave only.
    always_comb begin
        logic [31:0] rd;
        logic        ak;
        rd = '0;
        ak = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (sel[i]) begin
                rd = rd | s_dat_r[i*32 +: 32];
                ak = ak | s_ack[i];
            end
        end
        m_dat_r = rd;
        m_ack   = ak & m_stb;
    end

    // Pulse the error for one cycle on an unmapped strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= miss & ~err_q;
    end

    assign m_err = err_q;

    sar_irq_merge #(.IRQ_W(IRQ_W), .USED(IRQ_USED)) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .irq_spare (irq_spare)
    );

    // R2: never more than one slave strobed.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_stb));

    // R2: a write enable only goes with its own strobe.
    a_r2_we_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we & ~s_stb) == '0);

    // R7: an acknowledge to the master needs an acknowledging, strobed slave.
    a_r7_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> |(s_ack & s_stb));

    // R8: the error is a single-cycle pulse.
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |=> !m_err);

    // R8: an unmapped strobe is never acknowledged.
    a_r8_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && (s_stb == '0)) |-> !m_ack);

    // R10: reset clears the error.
    a_r10_reset_err: assert property (@(posedge clk)
        !rst_n |=> !m_err);

endmodule

// File: tb/test_sar_router.sv
// Directed bench for sar_router: one task per scenario, each checking its own results.
module test_sar_router;

    localparam int NS = 4;
    localparam logic [NS*32-1:0] BASES = {32'h0300_0000, 32'h0200_0000,
                                          32'h0400_0000, 32'h0100_0000};
    localparam logic [NS*8-1:0]  DECWS = {8'd8, 8'd8, 8'd8, 8'd8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0]    m_adr = '0;
    logic [31:0]    m_dat_w = '0;
    logic           m_we = 1'b0;
    logic           m_stb = 1'b0;
    logic [31:0]    m_dat_r;
    logic           m_ack;
    logic           m_err;
    logic [NS*32-1:0] s_adr;
    logic [31:0]    s_dat_w;
    logic [NS-1:0]  s_we;
    logic [NS-1:0]  s_stb;
    logic [NS*32-1:0] s_dat_r = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    logic [NS-1:0]  s_ack = '0;
    logic [7:0]     irq_in = '0;
    logic           irq_spare;

    sar_router #(
        .NS(NS), .IRQ_W(8), .SPACE_W(32), .SLV_BASE(BASES), .SLV_DECW(DECWS),
        .SLV_WORD(4'b1110), .SLV_DW({8'd8, 8'd16, 8'd32, 8'd32}),
        .SLV_AW({8'd8, 8'd12, 8'd4, 8'd20}), .IRQ_USED(8'b0000_1111)
    ) i_sar_router (
        .clk(clk), .rst_n(rst_n), .m_adr(m_adr), .m_dat_w(m_dat_w), .m_we(m_we),
        .m_stb(m_stb), .m_dat_r(m_dat_r), .m_ack(m_ack), .m_err(m_err),
        .s_adr(s_adr), .s_dat_w(s_dat_w), .s_we(s_we), .s_stb(s_stb),
        .s_dat_r(s_dat_r), .s_ack(s_ack), .irq_in(irq_in), .irq_spare(irq_spare)
    );

    // Second instance: 24-bit peripheral space, two byte-mode slaves.
    logic [31:0]  io_adr = '0;
    logic         io_stb = 1'b0;
    logic [31:0]  io_dat_r;
    logic         io_ack;
    logic         io_err;
    logic [63:0]  io_s_adr;
    logic [31:0]  io_s_dat_w;
    logic [1:0]   io_s_we;
    logic [1:0]   io_s_stb;
    logic [1:0]   io_irq = '0;
    logic         io_spare;

    sar_router #(
        .NS(2), .IRQ_W(2), .SPACE_W(24),
        .SLV_BASE({32'h0020_0000, 32'h0010_0000}), .SLV_DECW({8'd8, 8'd8}),
        .SLV_WORD(2'b00), .SLV_DW({8'd32, 8'd32}), .SLV_AW({8'd16, 8'd16}),
        .IRQ_USED(2'b11)
    ) i_sar_router_io (
        .clk(clk), .rst_n(rst_n), .m_adr(io_adr), .m_dat_w(32'h0), .m_we(1'b0),
        .m_stb(io_stb), .m_dat_r(io_dat_r), .m_ack(io_ack), .m_err(io_err),
        .s_adr(io_s_adr), .s_dat_w(io_s_dat_w), .s_we(io_s_we), .s_stb(io_s_stb),
        .s_dat_r(64'h2222_2222_1111_1111), .s_ack(2'b11), .irq_in(io_irq),
        .irq_spare(io_spare)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a master access at the falling edge; outputs settle before the next rise.
    task automatic drive(input logic [31:0] a, input logic stb, input logic we);
        @(negedge clk);
        m_adr = a; m_stb = stb; m_we = we;
        #2;
    endtask

    function automatic logic [31:0] expect_loc(input logic [31:0] a, input int sh, input int aw);
        return (a >> sh) & ((32'd1 << aw) - 32'd1);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R10 err low in reset", {31'b0, m_err}, 32'd0);
        check("R2 no strobe idle", {28'b0, s_stb}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_byte_mode();
        drive(32'h0100_ABCD, 1'b1, 1'b0);
        check("R1 slave0 selected", {28'b0, s_stb}, 32'h1);
        check("R3 byte mode local", s_adr[0 +: 32], expect_loc(32'h0100_ABCD, 0, 20));
        drive(32'h01FF_FFFF, 1'b1, 1'b0);
        check("R6 slave0 top cut", s_adr[0 +: 32], 32'h000F_FFFF);
    endtask

    task automatic t_word32();
        drive(32'h0400_003C, 1'b1, 1'b0);
        check("R1 slave1 selected", {28'b0, s_stb}, 32'h2);
        check("R4 word32 local", s_adr[32 +: 32], 32'h0000_000F);
        drive(32'h0400_0044, 1'b1, 1'b0);
        check("R6 slave1 wraps at 4 bits", s_adr[32 +: 32], expect_loc(32'h0400_0044, 2, 4));
    endtask

    task automatic t_word16_8();
        drive(32'h0200_0ABE, 1'b1, 1'b0);
        check("R5 word16 local", s_adr[64 +: 32], 32'h0000_055F);
        drive(32'h0300_12F3, 1'b1, 1'b0);
        check("R5 word8 same as byte", s_adr[96 +: 32], 32'h0000_00F3);
        check("R1 slave3 selected", {28'b0, s_stb}, 32'h8);
    endtask

    task automatic t_readmux();
        s_ack = 4'b1111;
        drive(32'h0400_0000, 1'b1, 1'b0);
        check("R7 read data slave1", m_dat_r, 32'hBBBB_0001);
        check("R7 ack slave1", {31'b0, m_ack}, 32'd1);
        s_ack = 4'b1101;
        #2;
        check("R7 foreign acks ignored", {31'b0, m_ack}, 32'd0);
        drive(32'h0300_0000, 1'b1, 1'b0);
        check("R7 read data slave3", m_dat_r, 32'hDDDD_0003);
        s_ack = '0;
    endtask

    task automatic t_write_route();
        m_dat_w = 32'hFACE_0123;
        drive(32'h0200_0010, 1'b1, 1'b1);
        check("R2 write strobe slave2", {28'b0, s_stb}, 32'h4);
        check("R2 write enable slave2", {28'b0, s_we}, 32'h4);
        check("R2 write data passed", s_dat_w, 32'hFACE_0123);
        drive(32'h0200_0010, 1'b0, 1'b1);
        check("R2 no strobe without master strobe", {28'b0, s_stb | s_we}, 32'h0);
    endtask

    task automatic t_miss();
        s_ack = 4'b1111;
        drive(32'h0500_0000, 1'b1, 1'b0);
        check("R8 no strobe on miss", {28'b0, s_stb}, 32'h0);
        check("R8 no ack on miss", {31'b0, m_ack}, 32'd0);
        check("R8 err not yet", {31'b0, m_err}, 32'd0);
        @(posedge clk);
        #2;
        check("R8 err after edge", {31'b0, m_err}, 32'd1);
        m_stb = 1'b0;
        @(posedge clk);
        #2;
        check("R8 err one cycle only", {31'b0, m_err}, 32'd0);
        drive(32'h0100_0000, 1'b1, 1'b0);
        @(posedge clk);
        #2;
        check("R8 no err on hit", {31'b0, m_err}, 32'd0);
        m_stb = 1'b0;
        s_ack = '0;
    endtask

    task automatic t_irq();
        @(negedge clk); irq_in = 8'h0F; #2;
        check("R9 used lines ignored", {31'b0, irq_spare}, 32'd0);
        irq_in = 8'h20; #2;
        check("R9 spare line raises", {31'b0, irq_spare}, 32'd1);
        irq_in = 8'h8F; #2;
        check("R9 mixed lines", {31'b0, irq_spare}, 32'd1);
        irq_in = 8'h00; #2;
        check("R9 all quiet", {31'b0, irq_spare}, 32'd0);
    endtask

    task automatic t_io_space();
        @(negedge clk);
        io_adr = 32'hAB10_0004; io_stb = 1'b1; #2;
        check("R1 io upper byte ignored", {30'b0, io_s_stb}, 32'h1);
        check("R3 io byte local", io_s_adr[0 +: 32], 32'h0000_0004);
        io_adr = 32'h0020_0008; #2;
        check("R1 io slave1", {30'b0, io_s_stb}, 32'h2);
        check("R7 io data", io_dat_r, 32'h2222_2222);
        io_stb = 1'b0;
    endtask

    task automatic t_overlap();
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                logic [31:0] mi, mj, bi, bj;
                mi = '0; mj = '0;
                for (int k = 0; k < 32; k++) begin
                    if (k >= 32 - int'(DECWS[i*8 +: 8])) mi[k] = 1'b1;
                    if (k >= 32 - int'(DECWS[j*8 +: 8])) mj[k] = 1'b1;
                end
                bi = BASES[i*32 +: 32];
                bj = BASES[j*32 +: 32];
                check("R11 regions disjoint", {31'b0, ((bi ^ bj) & mi & mj) == '0}, 32'd0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_byte_mode();
        t_word32();
        t_word16_8();
        t_readmux();
        t_write_route();
        t_miss();
        t_irq();
        t_io_space();
        t_overlap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule